// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel. It holds a 16-bit down counter that a front end loads with an initial count, together with a mode code and a flag that selects binary or BCD counting. The counter steps once for each pulse on a count-enable input. A gate input, whose role depends on the mode, either pauses counting or triggers it. The channel drives a single output waveform. The six modes cover a terminal-count flag, a retriggerable one-shot, a periodic rate pulse, a square wave, and two kinds of single strobe.

A latch request copies the live count into a snapshot register. Software can then read a stable value while the counter keeps running. The host byte sequencing and the decoding of the control word stay in a separate front end. That front end presents a complete count word, a mode code and the BCD flag with a one-cycle write strobe.

Top module: `timer_channel`

## Requirements
- R1: After reset, out_wave is 1, count_q is 0 and snap_q is 0.
- R2: A write (wr_count high for one cycle) takes count_val, mode and bcd. In mode 0, out_wave goes low in the cycle after the write and count_q equals count_val. After N counting pulses, count_q is 0 and out_wave is 1. Both then hold until the next write.
- R3: With bcd=1 the counter steps as four decimal digits, one digit per nibble with the least significant digit in bits 3:0. With bcd=0 it steps as a 16-bit binary number. A loaded count of 0 stands for 65536 (binary) or 10000 (BCD): one pulse after loading 0, count_q reads 0xFFFF or 0x9999.
- R4: In mode 1, a write alone does not start counting, and the gate level does not matter. A rising gate edge loads the count and drives out_wave low. out_wave returns high after N pulses. A later rising edge restarts the full count.
- R5: In mode 2 (N ≥ 2), out_wave is low only for the pulse interval in which count_q is 1. At the next pulse the counter reloads N, so the period is N pulses.
- R6: In mode 3 (N ≥ 2), out_wave is high for ceil(N/2) pulses and low for floor(N/2) pulses, and this repeats.
- R7: In mode 4, out_wave stays high for N pulses after a write. It then goes low for exactly one pulse interval and returns high for good.
- R8: In mode 5, pulses have no effect until a rising gate edge loads the count. After that edge the channel behaves as in mode 4.
- R9: In modes 0, 2, 3 and 4, while gate is 0, counting pulses change neither count_q nor out_wave.
- R10: A latch_req pulse copies count_q into snap_q on the next cycle. snap_q holds that value at all other times.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle counting pulse |
| wr_count | input | 1 | Write strobe for count, mode and BCD flag |
| count_val | input | 16 | Initial count |
| mode | input | 3 | Operating mode code |
| bcd | input | 1 | 1 = decimal counting |
| gate | input | 1 | Gate: suspend or trigger, depending on mode |
| latch_req | input | 1 | Capture the live count into the snapshot |
| out_wave | output | 1 | Channel output waveform |
| count_q | output | 16 | Live count |
| snap_q | output | 16 | Latched snapshot of the count |

## Verification
The hardest case to reach is the wrap of a zero load in BCD mode. The counter has to pass from 0 to 9999 and then run all ten thousand pulses to terminal count, with every digit borrow in between. The stimulus loads 0 in mode 0 with decimal counting and checks the first step. It then issues the remaining pulses with random idle gaps and checks that the output rises only on the last one. The odd-count extra interval of the square wave and the retrigger of the one-shot are reached by directed sequences. Random loads in the free-running modes are checked pulse by pulse against closed-form waveform functions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int TMR_DIGITS = 4;
  localparam int TMR_W = 4 * TMR_DIGITS;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic tmr_mode_e norm_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return tmr_mode_e'({1'b0, m[1:0]});
    return tmr_mode_e'(m);
  endfunction

  // one step down, binary or per-digit decimal with borrow chain
  function automatic logic [TMR_W-1:0] dec_one(input logic [TMR_W-1:0] v, input logic bcd);
    logic [TMR_W-1:0] res;
    logic borrow;
    if (!bcd) return v - TMR_W'(1);
    res = v;
    borrow = 1'b1;
    for (int i = 0; i < TMR_DIGITS; i++) begin
      if (borrow) begin
        if (v[i*4 +: 4] == 4'd0) res[i*4 +: 4] = 4'd9;
        else begin
          res[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return res;
  endfunction

  function automatic logic edge_triggered(input tmr_mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction
endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_d <= 1'b0;
    else        gate_d <= gate;
  end
  assign rise = gate & ~gate_d;
endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (take) held <= live;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_count,
  input  logic [W-1:0] count_val,
  input  logic [2:0]   mode,
  input  logic         bcd,
  input  logic         gate,
  input  logic         gate_rise,
  output logic [W-1:0] count_o,
  output logic         out_o,
  output logic         tick_o,
  output tmr_mode_e    mode_o
);
  logic [W-1:0] cnt_q, reload_q;
  tmr_mode_e    mode_q, wr_mode;
  logic         bcd_q, run_q, out_q, extra_q;
  logic         trig_mode, gate_ok, trig, tick, at_one, at_two;
  logic [W-1:0] dec1, dec2, half_load, wr_even;

  always_comb begin
    wr_mode   = norm_mode(mode);
    trig_mode = edge_triggered(mode_q);
    gate_ok   = trig_mode | gate;
    trig      = gate_rise & trig_mode;
    tick      = cnt_en & run_q & gate_ok & ~wr_count & ~trig;
    at_one    = (cnt_q == W'(1));
    at_two    = (cnt_q == W'(2));
    dec1      = dec_one(cnt_q, bcd_q);
    dec2      = dec_one(dec1, bcd_q);
    half_load = {reload_q[W-1:1], 1'b0};
    wr_even   = {count_val[W-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      run_q    <= 1'b0;
      out_q    <= 1'b1;
      extra_q  <= 1'b0;
    end else if (wr_count) begin
      mode_q   <= wr_mode;
      bcd_q    <= bcd;
      reload_q <= count_val;
      extra_q  <= 1'b0;
      cnt_q    <= (wr_mode == M_SQUARE) ? wr_even : count_val;
      run_q    <= ~edge_triggered(wr_mode);
      out_q    <= (wr_mode != M_TERM);
    end else if (trig) begin
      cnt_q   <= reload_q;
      run_q   <= 1'b1;
      extra_q <= 1'b0;
      out_q   <= (mode_q == M_HWSTB);
    end else if (tick) begin
      case (mode_q)
        M_TERM, M_ONESHOT: begin
          cnt_q <= dec1;
          if (at_one) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
        M_RATE: begin
          if (at_one) begin
            cnt_q <= reload_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= dec1;
            if (at_two) out_q <= 1'b0;
          end
        end
        M_SQUARE: begin
          if (extra_q) begin
            extra_q <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= half_load;
          end else if (at_two) begin
            if (out_q && reload_q[0]) begin
              extra_q <= 1'b1;
              cnt_q   <= dec2;
            end else begin
              out_q <= ~out_q;
              cnt_q <= half_load;
            end
          end else begin
            cnt_q <= dec2;
          end
        end
        default: begin
          if (!out_q) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            cnt_q <= dec1;
            if (at_one) out_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;
  assign tick_o  = tick;
  assign mode_o  = mode_q;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_count,
  input  logic [TMR_W-1:0] count_val,
  input  logic [2:0]       mode,
  input  logic             bcd,
  input  logic             gate,
  input  logic             latch_req,
  output logic             out_wave,
  output logic [TMR_W-1:0] count_q,
  output logic [TMR_W-1:0] snap_q
);
  logic      gate_rise_w;
  logic      tick_w;
  tmr_mode_e mode_e;
  logic [2:0] mode_w;

  tmr_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise_w)
  );

  tmr_core #(.W(TMR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_count(wr_count),
    .count_val(count_val), .mode(mode), .bcd(bcd), .gate(gate),
    .gate_rise(gate_rise_w), .count_o(count_q), .out_o(out_wave),
    .tick_o(tick_w), .mode_o(mode_e)
  );

  assign mode_w = mode_e;

  tmr_snapshot #(.W(TMR_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .take(latch_req), .live(count_q), .held(snap_q)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_count,
  input logic [2:0]  mode,
  input logic        latch_req,
  input logic        gate,
  input logic        out_wave,
  input logic [15:0] count_q,
  input logic [15:0] snap_q,
  input logic        tick,
  input logic        gate_rise,
  input logic [2:0]  mode_q
);
  logic level_mode;
  assign level_mode = (mode_q == 3'd0) || (mode_q == 3'd2) ||
                      (mode_q == 3'd3) || (mode_q == 3'd4);

  AST_TERM_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count && mode == 3'd0 |=> !out_wave); // R2
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_req |=> $stable(snap_q)); // R10
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> snap_q == $past(count_q)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_count && !gate_rise |=> $stable(count_q) && $stable(out_wave)); // R9
  AST_GATE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && !gate && !wr_count |=> $stable(count_q) && $stable(out_wave)); // R9
  AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 3'd2 && !out_wave && tick |=> out_wave); // R5
  AST_STROBE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4 || mode_q == 3'd5) && !out_wave && tick |=> out_wave); // R7
endmodule

bind timer_channel tmr_checker u_tmr_checker (
  .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .mode(mode),
  .latch_req(latch_req), .gate(gate), .out_wave(out_wave),
  .count_q(count_q), .snap_q(snap_q), .tick(tick_w),
  .gate_rise(gate_rise_w), .mode_q(mode_w)
);

// File: tb/test_timer_channel.sv
`timescale 1ns/1ps
module test_timer_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, wr_count = 1'b0, bcd = 1'b0, gate = 1'b1, latch_req = 1'b0;
  logic [15:0] count_val = '0;
  logic [2:0]  mode = '0;
  logic        out_wave;
  logic [15:0] count_q, snap_q;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  timer_channel i_timer_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_count(wr_count),
    .count_val(count_val), .mode(mode), .bcd(bcd), .gate(gate),
    .latch_req(latch_req), .out_wave(out_wave), .count_q(count_q), .snap_q(snap_q)
  );

  function automatic logic [15:0] to_bcd(input int d);
    return {4'(d / 1000 % 10), 4'(d / 100 % 10), 4'(d / 10 % 10), 4'(d % 10)};
  endfunction

  function automatic int exp_out(input int m, input int n, input int k);
    case (m)
      0: return (k >= n) ? 1 : 0;
      2: return ((k % n) == n - 1) ? 0 : 1;
      3: return ((k % n) < (n + 1) / 2) ? 1 : 0;
      default: return (k == n) ? 0 : 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int m, input logic [15:0] v, input logic b);
    @(negedge clk);
    mode = 3'(m); count_val = v; bcd = b; wr_count = 1'b1;
    @(negedge clk);
    wr_count = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 1)) @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic gate_pulse();
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int modes[4] = '{0, 2, 3, 4};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", out_wave, 1);
    chk("R1 count", count_q, 0);
    chk("R1 snap", snap_q, 0);

    // R2 mode 0 binary
    wr(0, 16'd9, 1'b0);
    chk("R2 low after write", out_wave, 0);
    chk("R2 loaded", count_q, 9);
    ticks(8);
    chk("R2 still low", out_wave, 0);
    chk("R2 count", count_q, 1);
    ticks(1);
    chk("R2 terminal high", out_wave, 1);
    chk("R2 terminal count", count_q, 0);
    ticks(3);
    chk("R2 stays high", out_wave, 1);
    chk("R2 stays zero", count_q, 0);

    // R3 BCD stepping and zero loads
    wr(0, 16'h0105, 1'b1);
    ticks(7);
    chk("R3 bcd borrow", count_q, 16'h0098);
    ticks(97);
    chk("R3 bcd near end", count_q, 1);
    ticks(1);
    chk("R3 bcd terminal", out_wave, 1);
    wr(0, 16'h0000, 1'b0);
    ticks(1);
    chk("R3 binary zero wraps", count_q, 16'hFFFF);
    ticks(2);
    chk("R3 binary step", count_q, 16'hFFFD);
    wr(0, 16'h0000, 1'b1);
    ticks(1);
    chk("R3 bcd zero wraps", count_q, 16'h9999);
    chk("R3 bcd zero low", out_wave, 0);
    ticks(9998);
    chk("R3 bcd zero before end", out_wave, 0);
    ticks(1);
    chk("R3 bcd zero 10000 pulses", out_wave, 1);

    // R4 one-shot
    gate = 1'b0;
    wr(1, 16'd6, 1'b0);
    ticks(3);
    chk("R4 write alone idle out", out_wave, 1);
    chk("R4 write alone idle count", count_q, 6);
    gate_pulse();
    chk("R4 trigger low", out_wave, 0);
    ticks(4);
    chk("R4 counting", count_q, 2);
    gate_pulse();
    chk("R4 retrigger reload", count_q, 6);
    ticks(5);
    chk("R4 retrigger still low", out_wave, 0);
    ticks(1);
    chk("R4 end high", out_wave, 1);

    // R8 hardware strobe
    gate = 1'b0;
    wr(5, 16'd4, 1'b0);
    ticks(2);
    chk("R8 idle before edge", count_q, 4);
    gate_pulse();
    ticks(3);
    chk("R8 before strobe", out_wave, 1);
    ticks(1);
    chk("R8 strobe low", out_wave, 0);
    ticks(1);
    chk("R8 strobe back high", out_wave, 1);

    // R7 software strobe
    gate = 1'b1;
    wr(4, 16'd7, 1'b0);
    ticks(6);
    chk("R7 high before", out_wave, 1);
    ticks(1);
    chk("R7 strobe low", out_wave, 0);
    ticks(1);
    chk("R7 back high", out_wave, 1);
    ticks(2);
    chk("R7 stays high", out_wave, 1);

    // R9 gate suspend
    wr(2, 16'd10, 1'b0);
    ticks(3);
    @(negedge clk); gate = 1'b0;
    ticks(4);
    chk("R9 count frozen", count_q, 7);
    chk("R9 out frozen", out_wave, 1);
    @(negedge clk); gate = 1'b1;
    ticks(1);
    chk("R9 resumes", count_q, 6);

    // R10 latch
    wr(0, 16'd100, 1'b0);
    ticks(10);
    @(negedge clk); latch_req = 1'b1;
    @(negedge clk); latch_req = 1'b0;
    chk("R10 captured", snap_q, 90);
    ticks(5);
    chk("R10 held", snap_q, 90);
    chk("R10 live moves", count_q, 85);

    // R11 alias codes
    wr(6, 16'd5, 1'b0);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      chk("R11 code 6 as rate", out_wave, exp_out(2, 5, k));
    end
    wr(7, 16'd5, 1'b0);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      chk("R11 code 7 as square", out_wave, exp_out(3, 5, k));
    end

    // random loads: R5 R6 R7 R2 R3
    for (int it = 0; it < 10; it++) begin
      int m = modes[$urandom_range(0, 3)];
      int n = int'($urandom_range(2, 30));
      logic b = 1'($urandom_range(0, 1));
      wr(m, b ? to_bcd(n) : 16'(n), b);
      for (int k = 1; k <= 2 * n + 2; k++) begin
        ticks(1);
        chk(m == 2 ? "R5 rate wave" : m == 3 ? "R6 square wave" :
            m == 4 ? "R7 strobe wave" : "R2 terminal wave",
            out_wave, exp_out(m, n, k));
        if ((m == 0 || m == 4) && k < n)
          chk("R3 random count", count_q, b ? to_bcd(n - k) : n - k);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule